// File: doc/BRIEF.md
# DS3 Alarm Indication Generator

This block builds a DS3 alarm indication signal as an NRZ bit stream, one bit per line clock. The signal is a properly structured M-frame. The overhead bits take fixed values, and the parity overhead carries the parity of the previous frame. Payload bits alternate 1, 0, 1, 0. The alternation starts again with a 1 right after every overhead bit.

An active-low alarm enable chooses the output source. When the enable is high, the incoming data stream passes through. When it is low, the generated alarm stream is sent instead. The frame position counters always run, so the alarm begins at whatever frame position the generator has reached. Line coding and clock recovery sit outside this block.

The frame has 7 subframes. Each subframe has 8 blocks, and each block is one overhead bit followed by 84 payload bits. That gives 680 bits per subframe and 4760 bits per frame.

Top module: `ds3_ais_gen`

## Requirements
- R1: While `rst_ni` is low, `data_o` is 0. After reset is released, the generator starts at frame bit 0, which is the first overhead bit of subframe 1.
- R2: With `ais_n_i` high, `data_o` equals the `data_i` sampled on the previous clock edge.
- R3: With `ais_n_i` low, `data_o` is the generated alarm bit for the current frame position, whatever the value of `data_i`.
- R4: Payload bit k of a block (k = 1..84, counted after its overhead bit) is 1 for odd k and 0 for even k.
- R5: The framing overhead in blocks 2 and 8 of each subframe is 1. In blocks 4 and 6 it is 0.
- R6: The overhead in blocks 3, 5 and 7 of every subframe is 0. The overhead in block 1 of subframes 1 and 2 is 1.
- R7: The overhead in block 1 is 0 for subframes 5 and 7, and 1 for subframe 6.
- R8: The overhead in block 1 of subframes 3 and 4 equals the XOR of all payload bits of the previous generated frame. In the first frame after reset it is 0.
- R9: A change on `ais_n_i` takes effect at the next clock edge. The frame position advances on every clock, whichever source is selected.
- R10: The alarm frame repeats every 4760 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Line-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ais_n_i | input | 1 | Active-low alarm enable |
| data_i | input | 1 | Pass-through NRZ data |
| data_o | output | 1 | NRZ output bit |

## Verification
The output register is the only stage between the inputs and `data_o`. Every output bit therefore belongs to the inputs and frame position sampled at the edge before it. The bench model samples the inputs at each rising edge and advances its own frame position there. It compares `data_o` at the following falling edge, on every cycle. The model latches parity when its frame ends, so the parity overhead of the next frame is checked against it. Toggling the enable within single cycles confirms that the selection follows one edge behind the enable.

// File: rtl/ds3_ais_pkg.sv
package ds3_ais_pkg;
  parameter int unsigned SUBFRAMES    = 7;
  parameter int unsigned BLOCKS       = 8;
  parameter int unsigned PAYLOAD_BITS = 84;

  typedef enum logic [2:0] {
    OH_X, OH_P, OH_M0, OH_M1, OH_F0, OH_F1, OH_C
  } oh_kind_e;

  // block order within a subframe: lead, F1, C, F0, C, F0, C, F1
  function automatic oh_kind_e oh_kind(input int unsigned sf, input int unsigned blk);
    oh_kind_e k;
    case (blk)
      0: begin
        case (sf)
          0, 1:    k = OH_X;
          2, 3:    k = OH_P;
          5:       k = OH_M1;
          default: k = OH_M0;
        endcase
      end
      1, 7:    k = OH_F1;
      3, 5:    k = OH_F0;
      default: k = OH_C;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/ais_frame_pos.sv
module ais_frame_pos #(
  parameter int unsigned SUBFRAMES    = 7,
  parameter int unsigned BLOCKS       = 8,
  parameter int unsigned PAYLOAD_BITS = 84,
  localparam int unsigned SF_W  = $clog2(SUBFRAMES),
  localparam int unsigned BLK_W = $clog2(BLOCKS),
  localparam int unsigned BIT_W = $clog2(PAYLOAD_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [SF_W-1:0]  sf_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             ovh_o,
  output logic             frame_end_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(PAYLOAD_BITS);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS - 1);
  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SUBFRAMES - 1);

  logic [SF_W-1:0]  sf_q;
  logic [BLK_W-1:0] blk_q;
  logic [BIT_W-1:0] bit_q;
  logic bit_wrap, blk_wrap;

  assign bit_wrap = (bit_q == BIT_LAST);
  assign blk_wrap = bit_wrap && (blk_q == BLK_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sf_q  <= '0;
      blk_q <= '0;
      bit_q <= '0;
    end else begin
      bit_q <= bit_wrap ? '0 : bit_q + 1'b1;
      if (bit_wrap) blk_q <= blk_wrap ? '0 : blk_q + 1'b1;
      if (blk_wrap) sf_q <= (sf_q == SF_LAST) ? '0 : sf_q + 1'b1;
    end
  end

  assign sf_o        = sf_q;
  assign blk_o       = blk_q;
  assign bit_o       = bit_q;
  assign ovh_o       = (bit_q == '0);
  assign frame_end_o = blk_wrap && (sf_q == SF_LAST);

  // R4: the first payload bit always follows an overhead bit
  assert_payload_after_ovh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovh_o |=> (bit_q == BIT_W'(1)));

  // R10: frame wraps to subframe 0, block 0, overhead slot
  assert_frame_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> (sf_q == '0 && blk_q == '0 && ovh_o));
endmodule

// File: rtl/ais_frame_parity.sv
module ais_frame_parity (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic payload_i,
  input  logic bit_i,
  input  logic frame_end_i,
  output logic parity_o
);
  logic acc_q, par_q, acc_nxt;

  assign acc_nxt = acc_q ^ (payload_i & bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      par_q <= 1'b0;
    end else if (frame_end_i) begin
      acc_q <= 1'b0;
      par_q <= acc_nxt;
    end else begin
      acc_q <= acc_nxt;
    end
  end

  assign parity_o = par_q;

  // R8: accumulation restarts cleanly each frame
  assert_acc_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (acc_q == 1'b0));

  // R8: latched parity only moves at a frame boundary
  assert_par_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(par_q));
endmodule

// File: rtl/ds3_ais_gen.sv
module ds3_ais_gen
  import ds3_ais_pkg::*;
#(
  parameter int unsigned N_SUBFRAMES = SUBFRAMES,
  parameter int unsigned N_BLOCKS    = BLOCKS,
  parameter int unsigned N_PAYLOAD   = PAYLOAD_BITS,
  localparam int unsigned SF_W  = $clog2(N_SUBFRAMES),
  localparam int unsigned BLK_W = $clog2(N_BLOCKS),
  localparam int unsigned BIT_W = $clog2(N_PAYLOAD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ais_n_i,
  input  logic data_i,
  output logic data_o
);
  logic [SF_W-1:0]  sf;
  logic [BLK_W-1:0] blk;
  logic [BIT_W-1:0] bit_idx;
  logic ovh, frame_end, parity, ais_bit, ovh_bit, out_q;

  ais_frame_pos #(
    .SUBFRAMES(N_SUBFRAMES), .BLOCKS(N_BLOCKS), .PAYLOAD_BITS(N_PAYLOAD)
  ) i_pos (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sf_o(sf), .blk_o(blk), .bit_o(bit_idx),
    .ovh_o(ovh), .frame_end_o(frame_end)
  );

  ais_frame_parity i_par (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .payload_i(!ovh), .bit_i(ais_bit),
    .frame_end_i(frame_end), .parity_o(parity)
  );

  always_comb begin
    case (oh_kind(int'(sf), int'(blk)))
      OH_X, OH_M1, OH_F1: ovh_bit = 1'b1;
      OH_P:               ovh_bit = parity;
      default:            ovh_bit = 1'b0;
    endcase
  end

  // odd payload index -> 1, so each block's payload opens with a 1
  assign ais_bit = ovh ? ovh_bit : bit_idx[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= ais_n_i ? data_i : ais_bit;
  end

  assign data_o = out_q;

  // R2
  assert_pass_through_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ais_n_i |=> (data_o == $past(data_i)));

  // R3
  assert_alarm_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ais_n_i |=> (data_o == $past(ais_bit)));
endmodule

// File: tb/test_ds3_ais_gen.sv
module test_ds3_ais_gen;
  localparam int unsigned BLK_LEN   = 85;
  localparam int unsigned SF_LEN    = 8 * BLK_LEN;
  localparam int unsigned FRAME_LEN = 7 * SF_LEN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ais_n = 1'b1;
  logic din = 1'b0;
  logic dout;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  ds3_ais_gen i_ds3_ais_gen (
    .clk_i(clk), .rst_ni(rst_n), .ais_n_i(ais_n), .data_i(din), .data_o(dout)
  );

  always #2.5 clk = ~clk;

  // reference model state
  int pos = 0;
  bit acc = 1'b0;
  bit par = 1'b0;
  bit exp_bit = 1'b0;
  string exp_tag = "R1";
  bit prev_ais_n = 1'b1;

  function automatic bit gen_bit(input int p, input bit pq, output string tag);
    int off, blk, sf;
    off = p % BLK_LEN;
    blk = (p / BLK_LEN) % 8;
    sf  = p / SF_LEN;
    if (off != 0) begin
      tag = "R4";
      return bit'(off % 2);
    end
    if (p == 0) tag = "R10"; else tag = "R6";
    case (blk)
      1, 7: begin tag = "R5"; return 1'b1; end
      3, 5: begin tag = "R5"; return 1'b0; end
      2, 4, 6: return 1'b0;
      default: begin
        if (sf < 2) return 1'b1;
        if (sf < 4) begin tag = "R8"; return pq; end
        if (p != 0) tag = "R7";
        return (sf == 5);
      end
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = 0; acc = 1'b0; par = 1'b0;
      exp_bit = 1'b0; exp_tag = "R1"; prev_ais_n = 1'b1;
    end else begin
      string t;
      bit g;
      g = gen_bit(pos, par, t);
      if (pos % BLK_LEN != 0) acc = acc ^ g;
      if (ais_n) begin
        exp_bit = din; exp_tag = "R2";
      end else begin
        exp_bit = g; exp_tag = t;
        if (prev_ais_n) exp_tag = "R9";
        else if (t == "R4" && din == g) exp_tag = "R4";
        else if (t == "R4") exp_tag = "R3";
      end
      prev_ais_n = ais_n;
      if (pos == FRAME_LEN - 1) begin par = acc; acc = 1'b0; pos = 0; end
      else pos = pos + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (dout !== exp_bit) begin
        n_errors++;
        $display("FAIL %s: data_o=%0b expected %0b (model pos %0d)", exp_tag, dout, exp_bit, pos);
      end
    end
  end

  task automatic run(input int n, input bit alarm_n, input bit toggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din = 1'($urandom);
      ais_n = toggle ? 1'($urandom) : alarm_n;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;                       // R1 checked during reset cycles
    run(300, 1'b1, 1'b0);               // R2 pass-through
    run(3 * FRAME_LEN + 50, 1'b0, 1'b0); // R3-R8, R10 alarm frames
    run(400, 1'b1, 1'b0);
    run(600, 1'b0, 1'b1);               // R9 single-cycle toggles
    run(FRAME_LEN, 1'b0, 1'b0);
    run(100, 1'b1, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule